// File: doc/BRIEF.md
# Bus Yield Controller

This block decides when a processor core hands its shared address and data buses to an outside master, and when it takes them back. The outside master pulls an active-low request line, which may change at any time relative to the core clock. The controller brings the request into the clock domain through a chain of flops. It then grants the buses once the core is not partway through an external memory access. When it grants, it switches off the core's address, data, memory-select, read and write drivers through one enable.

The core normally stops while the buses are away. In run-on mode it keeps executing instructions that need no external memory. It stops only when it reaches one that does, and it holds that access back until the buses return. When the request goes away, the grant is withdrawn, the drivers come back on and the core continues from where it stopped. The handshake does not depend on the core reset: it keeps working while the core is held in reset.

All pins are plain level control signals. No data moves through the block, so it has no valid/ready interface.

Top module: `bus_yield_ctrl`

## Requirements
- R1: With no external access in progress, a request is granted `SYNC_STAGES+1` clock edges after `bus_req_n` falls. From that edge on, `bus_grant_n` is 0, `drv_oe` is 0 and, outside run-on mode, `core_halt` is 1.
- R2: While `acc_busy` is 1 and `acc_done` is 0, no grant is given. A grant that was held back appears on the edge that ends the cycle in which `acc_done` is 1.
- R3: For an access of any length from 1 to 8 cycles, the first granted edge is the larger of `SYNC_STAGES+1` and the access length. Edges are counted from the cycle in which both the request and the access begin.
- R4: The grant may fall between two accesses of one instruction. When `acc_done` is 1 and `acc_busy` stays 1 for a following access, the grant is still given on the next edge.
- R5: In run-on mode (`run_on` = 1 when the grant is given), the grant is given with `core_halt` at 0 for as long as `need_ext` stays 0.
- R6: In run-on mode, while granted, `need_ext` = 1 raises `core_halt` at once. `core_halt` then stays 1 until the grant is withdrawn, even if `need_ext` returns to 0.
- R7: `SYNC_STAGES+1` edges after `bus_req_n` rises, `bus_grant_n` returns to 1 and `drv_oe` to 1 on the same edge. `core_halt` falls on that edge unless the core is in reset.
- R8: While `core_rst_n` is 0, `core_halt` is 1, `acc_busy` is ignored, and requests are still granted and released with the R1 and R7 timing.
- R9: `run_on` is sampled only on the edge that gives the grant. Changing it during a grant has no effect on `core_halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core reset, active low; does not stop the handshake |
| bus_req_n | input | 1 | Bus request from the outside master, active low, asynchronous |
| run_on | input | 1 | 1 selects run-on mode for the next grant |
| acc_busy | input | 1 | An external memory access is in progress |
| acc_done | input | 1 | Last cycle of the current external access |
| need_ext | input | 1 | The instruction about to execute needs external memory |
| bus_grant_n | output | 1 | Bus grant to the outside master, active low |
| drv_oe | output | 1 | Enable for the address, data, select, read and write drivers |
| core_halt | output | 1 | Stops core execution |

## Verification
The bench builds the block with the default of two synchronizer stages, which gives a request-to-grant latency of three edges. It sweeps access lengths from none up to eight cycles, both with and without a second access that follows at once. Because some accesses end before the synchronized request arrives and some end after, the sweep reaches both sides of the larger-of rule in R3. It checks grant, driver enable and halt on every cycle of each run. Run-on entry, the sticky halt, mode changes in the middle of a grant, and a full handshake under core reset are covered as separate sequences.

// File: rtl/yield_pkg.sv
package yield_pkg;
  // Status of the core's external memory activity, as seen by the controller.
  typedef struct packed {
    logic busy;  // access in progress
    logic done;  // final cycle of that access
    logic need;  // upcoming instruction needs external memory
  } core_acc_t;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b0
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  // No reset: the request path must keep working while the core is reset.
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d_async;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/yield_grant.sv
module yield_grant
  import yield_pkg::*;
(
  input  logic      clk,
  input  logic      core_rst_n,
  input  logic      req_s,
  input  core_acc_t acc,
  output logic      grant_q,
  output logic      grant_rise
);
  logic busy_m;
  logic grant_d;

  // During core reset no access can be in progress.
  assign busy_m  = acc.busy & core_rst_n;
  assign grant_d = req_s & (grant_q | ~busy_m | acc.done);
  assign grant_rise = grant_d & ~grant_q;

  logic grant_r = 1'b0;
  always_ff @(posedge clk) grant_r <= grant_d;
  assign grant_q = grant_r;

  p_idle_grant_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!grant_q && req_s && !acc.busy) |=> grant_q);
  p_defer_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!grant_q && acc.busy && !acc.done) |=> !grant_q);
  p_between_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!grant_q && req_s && acc.busy && acc.done) |=> grant_q);
  p_release_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (grant_q && !req_s) |=> !grant_q);
endmodule

// File: rtl/yield_halt.sv
module yield_halt
  import yield_pkg::*;
(
  input  logic      clk,
  input  logic      core_rst_n,
  input  logic      grant_q,
  input  logic      grant_rise,
  input  logic      run_on,
  input  core_acc_t acc,
  output logic      core_halt
);
  logic go_q    = 1'b0;
  logic stall_q = 1'b0;

  // Mode is captured once, on the edge that gives the grant.
  always_ff @(posedge clk) begin
    if (grant_rise) go_q <= run_on;
  end

  // Once run-on meets an external need, execution stays stopped.
  always_ff @(posedge clk) begin
    stall_q <= grant_q & go_q & (acc.need | stall_q);
  end

  assign core_halt = ~core_rst_n | (grant_q & (~go_q | acc.need | stall_q));

  p_run_until_need_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($rose(grant_q) && $past(run_on) && !acc.need) |-> !core_halt);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (grant_q && go_q && acc.need) |=> (core_halt || !grant_q));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (grant_q && !grant_rise) |=> $stable(go_q));

  always @(posedge clk) begin
    if (!core_rst_n) p_reset_halt_r8: assert (core_halt);
  end
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import yield_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic core_rst_n,
  input  logic bus_req_n,
  input  logic run_on,
  input  logic acc_busy,
  input  logic acc_done,
  input  logic need_ext,
  output logic bus_grant_n,
  output logic drv_oe,
  output logic core_halt
);
  core_acc_t acc;
  logic      req_s;
  logic      grant_q;
  logic      grant_rise;

  assign acc = '{busy: acc_busy, done: acc_done, need: need_ext};

  yield_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync (
    .clk     (clk),
    .d_async (~bus_req_n),
    .q_sync  (req_s)
  );

  yield_grant u_grant (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .req_s      (req_s),
    .acc        (acc),
    .grant_q    (grant_q),
    .grant_rise (grant_rise)
  );

  yield_halt u_halt (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .grant_q    (grant_q),
    .grant_rise (grant_rise),
    .run_on     (run_on),
    .acc        (acc),
    .core_halt  (core_halt)
  );

  // Drivers go off on exactly the edge the grant goes out, and back on with its release.
  assign bus_grant_n = ~grant_q;
  assign drv_oe      = ~grant_q;
endmodule

// File: tb/bus_yield_ctrl_tb.sv
module bus_yield_ctrl_tb;
  localparam int SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic core_rst_n, bus_req_n, run_on, acc_busy, acc_done, need_ext;
  logic bus_grant_n, drv_oe, core_halt;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_yield_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .core_rst_n(core_rst_n), .bus_req_n(bus_req_n), .run_on(run_on),
    .acc_busy(acc_busy), .acc_done(acc_done), .need_ext(need_ext),
    .bus_grant_n(bus_grant_n), .drv_oe(drv_oe), .core_halt(core_halt)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic granted, input logic halt);
    chk(tag, "bus_grant_n", bus_grant_n, ~granted);
    chk(tag, "drv_oe", drv_oe, ~granted);
    chk(tag, "core_halt", core_halt, halt);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    core_rst_n = 1'b0; bus_req_n = 1'b1; run_on = 1'b0;
    acc_busy = 1'b0; acc_done = 1'b0; need_ext = 1'b0;
    step(3);
    chk_all("R8", 1'b0, 1'b1);          // reset state: no grant, core held
    core_rst_n = 1'b1;
    step(1);
    chk_all("R8", 1'b0, 1'b0);          // out of reset: core running

    // Sweep access length L (0 = none) and an optional second access (R1..R4, R7).
    for (int L = 0; L <= 8; L++) begin
      for (int v = 0; v <= 1; v++) begin
        string tag;
        int exp;
        if (v == 1 && L < 3) continue;
        exp = (L > LAT) ? L : LAT;
        if (L == 0) tag = "R1";
        else if (v == 1) tag = "R4";
        else if (L > LAT) tag = "R3";
        else tag = "R2";
        bus_req_n = 1'b0;
        acc_busy  = (L > 0);
        acc_done  = (L == 1);
        for (int c = 0; c < 12; c++) begin
          step(1);
          chk_all(tag, (c + 1 >= exp), (c + 1 >= exp));
          acc_busy = (c + 1 < L) || (v == 1 && c + 1 == L);
          acc_done = (c + 1 == L - 1);
        end
        acc_busy = 1'b0; acc_done = 1'b0;
        bus_req_n = 1'b1;
        for (int c = 1; c <= LAT; c++) begin
          step(1);
          chk_all("R7", (c < LAT), (c < LAT));
        end
        step(2);
      end
    end

    // Run-on mode captured at grant; later mode change ignored.
    run_on = 1'b1; bus_req_n = 1'b0;
    step(LAT);
    chk_all("R5", 1'b1, 1'b0);
    run_on = 1'b0;
    step(2);
    chk("R9", "core_halt", core_halt, 1'b0);
    need_ext = 1'b1;
    step(1);
    chk("R6", "core_halt", core_halt, 1'b1);
    need_ext = 1'b0;
    step(1);
    chk("R6", "core_halt sticky", core_halt, 1'b1);
    step(2);
    chk("R6", "core_halt sticky", core_halt, 1'b1);
    bus_req_n = 1'b1;
    step(LAT - 1);
    chk_all("R7", 1'b1, 1'b1);
    step(1);
    chk_all("R7", 1'b0, 1'b0);
    step(2);

    // Normal grant, then run_on raised mid-grant: halt must stay.
    run_on = 1'b0; bus_req_n = 1'b0;
    step(LAT);
    chk_all("R1", 1'b1, 1'b1);
    run_on = 1'b1;
    step(2);
    chk("R9", "core_halt", core_halt, 1'b1);
    bus_req_n = 1'b1; run_on = 1'b0;
    step(LAT);
    chk_all("R7", 1'b0, 1'b0);
    step(2);

    // Handshake under core reset, with a stuck busy that must be ignored.
    core_rst_n = 1'b0; acc_busy = 1'b1; bus_req_n = 1'b0;
    step(LAT - 1);
    chk_all("R8", 1'b0, 1'b1);
    step(1);
    chk_all("R8", 1'b1, 1'b1);
    bus_req_n = 1'b1;
    step(LAT);
    chk_all("R8", 1'b0, 1'b1);
    acc_busy = 1'b0; core_rst_n = 1'b1;
    step(1);
    chk_all("R8", 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule